// File: doc/BRIEF.md
# External Data Memory Access Controller

This block sits between an 8-bit CPU core and an external data memory. The core writes a set of byte-wide address registers and a stretch register through a simple register port. It then issues one access at a time through a valid/ready request channel. The controller builds a 24-bit address, drives a read or write strobe for a programmable number of clocks, and raises a one-cycle completion pulse that carries the read data back to the core.

The address comes from one of two sources. The pointer source joins a page byte, a high pointer byte and a low pointer byte. The index source joins two extension bytes with an 8-bit index byte. Read data and write data use separate ports. A drive-enable output controls an external tri-state buffer, and it brackets the write strobe by one cycle on each side. The address and data buses are not multiplexed, so no latch-enable pin exists.

Back-pressure: a request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle. A request presented while `req_ready` is low is not taken and has no effect. The core does not need to hold it. The completion pulse `done` has no ready signal, so the core must take `rd_data` in the cycle `done` is high.

Top module: `xmem_ctrl`

## Requirements
- R1: After reset the controller is idle. `req_ready` is 1; `mem_rd`, `mem_wr`, `mem_wdata_oe` and `done` are 0. All address registers and the stretch value are 0, so the first access has a 1-clock strobe at address 0.
- R2: With `req_src`=0 the access address is {page, pointer high, pointer low}. Page is in bits 23:16 and pointer low is in bits 7:0.
- R3: With `req_src`=1 the access address is {extension high, extension middle, index}. The index byte is in bits 7:0.
- R4: With stretch value N in 0..7 (register select 6, `cfg_wdata[2:0]`), `mem_rd` or `mem_wr` stays high for exactly N+1 consecutive clocks. The two strobes are never high together.
- R5: The address, the write data and the strobe length are captured when the request is accepted. Register writes made during the access do not change them.
- R6: For a write, `mem_wdata_oe` rises one clock before `mem_wr` rises and falls one clock after `mem_wr` falls. For a read it stays 0.
- R7: Read data is sampled from `mem_rdata` in the last strobe clock. It is presented on `rd_data` while `done` is high.
- R8: `done` is a single-clock pulse in the clock right after the strobe ends. `req_ready` returns to 1 in the following clock.
- R9: A request made while `req_ready` is 0 is ignored. No second strobe follows, and the address is not changed.
- R10: Register select codes are: 0 pointer low, 1 pointer high, 2 page, 3 index, 4 extension middle, 5 extension high, 6 stretch. A write takes effect at the clock edge where `cfg_we` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | 8 | Register write data |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_src | input | 1 | Address source: 0 pointer, 1 index |
| req_wdata | input | 8 | Write data for the access |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Read data, valid with done |
| mem_addr | output | 24 | External memory address |
| mem_wdata | output | 8 | Data toward memory |
| mem_wdata_oe | output | 1 | Drive enable for external data buffer |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_rdata | input | 8 | Data from memory |

## Verification
A corrupt strobe counter shows at the pins within one access: the strobe runs longer or shorter than N+1 clocks, and `done` appears early or late. A state machine that skips the setup step shows `mem_wr` rising together with `mem_wdata_oe` on the first write. A missing capture stage shows as an address or data change in the middle of a strobe when registers are rewritten during the access. The bench feeds a read value that changes every clock, so sampling in the wrong strobe cycle returns a wrong `rd_data` at the very next `done`.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  localparam int SEL_W = 3;

  localparam logic [SEL_W-1:0] SEL_PTR_LO  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_PTR_HI  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_PAGE    = 3'd2;
  localparam logic [SEL_W-1:0] SEL_INDEX   = 3'd3;
  localparam logic [SEL_W-1:0] SEL_EXT_MID = 3'd4;
  localparam logic [SEL_W-1:0] SEL_EXT_HI  = 3'd5;
  localparam logic [SEL_W-1:0] SEL_STRETCH = 3'd6;

  localparam int NUM_BYTE_REGS = 6;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_STRB  = 2'd2,
    ST_FIN   = 2'd3
  } xm_state_e;
endpackage

// File: rtl/xmem_regs.sv
module xmem_regs
  import xmem_pkg::*;
#(
  parameter int DW = 8,
  parameter int SW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [DW-1:0]    cfg_wdata,
  output logic [DW-1:0]    ptr_lo,
  output logic [DW-1:0]    ptr_hi,
  output logic [DW-1:0]    page,
  output logic [DW-1:0]    index,
  output logic [DW-1:0]    ext_mid,
  output logic [DW-1:0]    ext_hi,
  output logic [SW-1:0]    stretch
);
  logic [DW-1:0] bank [NUM_BYTE_REGS];

  for (genvar g = 0; g < NUM_BYTE_REGS; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) begin
        bank[g] <= '0;
      end else if (cfg_we && (cfg_sel == SEL_W'(g))) begin
        bank[g] <= cfg_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stretch <= '0;
    end else if (cfg_we && (cfg_sel == SEL_STRETCH)) begin
      stretch <= cfg_wdata[SW-1:0];
    end
  end

  assign ptr_lo  = bank[SEL_PTR_LO];
  assign ptr_hi  = bank[SEL_PTR_HI];
  assign page    = bank[SEL_PAGE];
  assign index   = bank[SEL_INDEX];
  assign ext_mid = bank[SEL_EXT_MID];
  assign ext_hi  = bank[SEL_EXT_HI];
endmodule

// File: rtl/xmem_addr.sv
module xmem_addr #(
  parameter int DW = 8,
  localparam int AW = 3 * DW
) (
  input  logic          src_index,
  input  logic [DW-1:0] ptr_lo,
  input  logic [DW-1:0] ptr_hi,
  input  logic [DW-1:0] page,
  input  logic [DW-1:0] index,
  input  logic [DW-1:0] ext_mid,
  input  logic [DW-1:0] ext_hi,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] ptr_addr;
  logic [AW-1:0] idx_addr;

  assign ptr_addr = {page, ptr_hi, ptr_lo};
  assign idx_addr = {ext_hi, ext_mid, index};
  assign addr     = src_index ? idx_addr : ptr_addr;
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
#(
  parameter int DW = 8,
  parameter int SW = 3,
  localparam int AW = 3 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [SW-1:0] stretch,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_wdata_oe,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          done,
  output logic [DW-1:0] rd_data
);
  xm_state_e     state;
  logic [SW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;
  logic          is_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      is_wr   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            is_wr   <= req_write;
            cnt     <= stretch;
            state   <= req_write ? ST_SETUP : ST_STRB;
          end
        end
        ST_SETUP: state <= ST_STRB;
        ST_STRB: begin
          if (cnt == '0) begin
            state <= ST_FIN;
            if (!is_wr) rdata_q <= mem_rdata;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_FIN: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready    = (state == ST_IDLE);
  assign mem_rd       = (state == ST_STRB) && !is_wr;
  assign mem_wr       = (state == ST_STRB) && is_wr;
  assign mem_wdata_oe = is_wr && (state != ST_IDLE);
  assign done         = (state == ST_FIN);
  assign mem_addr     = addr_q;
  assign mem_wdata    = wdata_q;
  assign rd_data      = rdata_q;
endmodule

// File: rtl/xmem_ctrl.sv
module xmem_ctrl
  import xmem_pkg::*;
#(
  parameter int DW = 8,
  parameter int SW = 3,
  localparam int AW = 3 * DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic             req_src,
  input  logic [DW-1:0]    req_wdata,
  output logic             done,
  output logic [DW-1:0]    rd_data,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             mem_wdata_oe,
  output logic             mem_rd,
  output logic             mem_wr,
  input  logic [DW-1:0]    mem_rdata
);
  logic [DW-1:0] ptr_lo, ptr_hi, page, index, ext_mid, ext_hi;
  logic [SW-1:0] stretch;
  logic [AW-1:0] req_addr;

  xmem_regs #(.DW(DW), .SW(SW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .ptr_lo   (ptr_lo),
    .ptr_hi   (ptr_hi),
    .page     (page),
    .index    (index),
    .ext_mid  (ext_mid),
    .ext_hi   (ext_hi),
    .stretch  (stretch)
  );

  xmem_addr #(.DW(DW)) u_addr (
    .src_index(req_src),
    .ptr_lo   (ptr_lo),
    .ptr_hi   (ptr_hi),
    .page     (page),
    .index    (index),
    .ext_mid  (ext_mid),
    .ext_hi   (ext_hi),
    .addr     (req_addr)
  );

  xmem_seq #(.DW(DW), .SW(SW)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .stretch     (stretch),
    .mem_rdata   (mem_rdata),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_wdata_oe(mem_wdata_oe),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .done        (done),
    .rd_data     (rd_data)
  );
endmodule

// File: rtl/xmem_ctrl_chk.sv
module xmem_ctrl_chk #(
  parameter int DW = 8,
  parameter int SW = 3,
  localparam int AW = 3 * DW,
  localparam int MAXW = 1 << SW
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          done,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_wdata_oe,
  input logic          mem_rd,
  input logic          mem_wr
);
  logic [SW:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= '0;
    end else if (mem_rd || mem_wr) begin
      run <= (run == '1) ? run : run + 1'b1;
    end else begin
      run <= '0;
    end
  end

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  assert_strobe_max_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |-> (run < (SW+1)'(MAXW)));

  assert_wr_under_oe_R6: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> mem_wdata_oe);

  assert_oe_lead_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_wr) |-> $past(mem_wdata_oe));

  assert_oe_trail_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_wr) |-> mem_wdata_oe);

  assert_no_oe_on_read_R6: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> !mem_wdata_oe);

  assert_addr_stable_R5: assert property (@(posedge clk) disable iff (rst)
    ((mem_rd || mem_wr) && $past(mem_rd || mem_wr)) |-> $stable(mem_addr));

  assert_wdata_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_wdata_oe && $past(mem_wdata_oe)) |-> $stable(mem_wdata));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_after_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!mem_rd && !mem_wr && $past(mem_rd || mem_wr)));

  assert_done_then_ready_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> req_ready);

  assert_ready_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!mem_rd && !mem_wr && !mem_wdata_oe && !done));
endmodule

bind xmem_ctrl xmem_ctrl_chk #(.DW(DW), .SW(SW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_ready   (req_ready),
  .done        (done),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .mem_wdata_oe(mem_wdata_oe),
  .mem_rd      (mem_rd),
  .mem_wr      (mem_wr)
);

// File: tb/sim_xmem_ctrl.sv
module sim_xmem_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [7:0]  cfg_wdata;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic        req_src;
  logic [7:0]  req_wdata;
  logic        done;
  logic [7:0]  rd_data;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_wdata_oe;
  logic        mem_rd;
  logic        mem_wr;
  logic [7:0]  mem_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] mreg [6];
  logic [2:0] mstr;

  always #5 clk = ~clk;

  xmem_ctrl u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_src(req_src), .req_wdata(req_wdata), .done(done), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_addr(input bit src);
    return src ? {mreg[5], mreg[4], mreg[3]} : {mreg[2], mreg[1], mreg[0]};
  endfunction

  // R10: select map, write takes effect at the edge with cfg_we high
  task automatic put_reg(input logic [2:0] sel, input logic [7:0] val);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel == 3'd6) mstr = val[2:0];
    else if (sel < 3'd6) mreg[sel] = val;
  endtask

  task automatic access(input bit wr, input bit src, input logic [7:0] wd,
                        input logic [7:0] base, input bit poke);
    logic [23:0] ea;
    int n;
    ea = exp_addr(src);
    n = mstr;
    chk(req_ready === 1'b1, "R8 ready before request", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_src = src; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      // R9: request while busy; R5: register rewrites during access
      req_valid = 1'b1; req_write = !wr; req_src = !src; req_wdata = ~wd;
      cfg_we = 1'b1; cfg_sel = src ? 3'd3 : 3'd0; cfg_wdata = ~ea[7:0];
    end
    if (wr) begin
      chk(mem_wdata_oe === 1'b1 && mem_wr === 1'b0, "R6 enable leads strobe",
          {mem_wdata_oe, mem_wr}, 2'b10);
      chk(req_ready === 1'b0, "R9 busy ready low", req_ready, 0);
      @(negedge clk);
      if (poke) begin
        req_valid = 1'b0; cfg_we = 1'b0;
        mreg[src ? 3 : 0] = ~ea[7:0];
        poke = 0;
      end
    end
    for (int k = 0; k <= n; k++) begin
      mem_rdata = base ^ 8'(k * 37);
      chk((wr ? mem_wr : mem_rd) === 1'b1 && (wr ? mem_rd : mem_wr) === 1'b0,
          "R4 strobe active", {mem_rd, mem_wr}, wr ? 2'b01 : 2'b10);
      chk(mem_addr === ea, src ? "R3 index address" : "R2 pointer address", mem_addr, ea);
      if (k > 0) chk(mem_addr === ea, "R5 address held", mem_addr, ea);
      if (wr) chk(mem_wdata === wd && mem_wdata_oe === 1'b1, "R5 write data held",
                  mem_wdata, wd);
      else chk(mem_wdata_oe === 1'b0, "R6 no enable on read", mem_wdata_oe, 0);
      chk(done === 1'b0, "R8 no done during strobe", done, 0);
      @(negedge clk);
      if (poke) begin
        req_valid = 1'b0; cfg_we = 1'b0;
        mreg[src ? 3 : 0] = ~ea[7:0];
        poke = 0;
      end
    end
    chk(mem_rd === 1'b0 && mem_wr === 1'b0, "R4 strobe ends after N+1", {mem_rd, mem_wr}, 0);
    chk(done === 1'b1, "R8 done after strobe", done, 1);
    chk(mem_wdata_oe === wr, "R6 enable trails strobe", mem_wdata_oe, wr);
    if (!wr) chk(rd_data === (base ^ 8'(n * 37)), "R7 read data last cycle", rd_data,
                 base ^ 8'(n * 37));
    @(negedge clk);
    chk(done === 1'b0 && req_ready === 1'b1, "R8 single pulse then ready",
        {done, req_ready}, 2'b01);
    chk(mem_wdata_oe === 1'b0, "R6 enable off", mem_wdata_oe, 0);
    chk(mem_rd === 1'b0 && mem_wr === 1'b0, "R9 no strobe from ignored request",
        {mem_rd, mem_wr}, 0);
    chk(mem_addr === ea, "R9 address unchanged", mem_addr, ea);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    rst = 1'b1; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    req_valid = 0; req_write = 0; req_src = 0; req_wdata = 0; mem_rdata = 0;
    for (int i = 0; i < 6; i++) mreg[i] = 8'h00;
    mstr = 3'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(req_ready === 1'b1 && done === 1'b0, "R1 idle after reset", {req_ready, done}, 2'b10);
    chk({mem_rd, mem_wr, mem_wdata_oe} === 3'b000, "R1 pins quiet",
        {mem_rd, mem_wr, mem_wdata_oe}, 0);
    // R1: default stretch 0 gives one-clock read at address 0
    access(0, 0, 8'h00, 8'h5A, 0);
    // R2, R3 directed with distinct bytes
    put_reg(3'd0, 8'h11); put_reg(3'd1, 8'h22); put_reg(3'd2, 8'h33);
    put_reg(3'd3, 8'h44); put_reg(3'd4, 8'h55); put_reg(3'd5, 8'h66);
    access(0, 0, 8'h00, 8'hC3, 0);
    access(1, 1, 8'hA5, 8'h00, 0);
    // R4 extremes
    put_reg(3'd6, 8'hF7);
    access(0, 1, 8'h00, 8'h81, 0);
    access(1, 0, 8'h3C, 8'h00, 0);
    // R5 / R9 with rewrites and busy requests
    access(0, 0, 8'h00, 8'h17, 1);
    access(1, 1, 8'hE1, 8'h00, 1);
    put_reg(3'd6, 8'h00);
    access(0, 1, 8'h00, 8'h99, 1);
    access(1, 0, 8'h42, 8'h00, 1);
    // random mix
    for (int t = 0; t < 60; t++) begin
      int r;
      r = $urandom_range(0, 3);
      for (int q = 0; q < r; q++) put_reg(3'($urandom_range(0, 6)), 8'($urandom));
      access(1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule